// File: doc/BRIEF.md
# Short-Format Two-Level Page Table Walker

This block resolves one 32-bit virtual address against two-level short-format translation tables held in memory. A walk is started with a virtual address, the base of a 16 KB-aligned first-level table and two mode bits. The block reads the first-level entry selected by the top twelve address bits. That entry may be a fault, a reserved code, a 1 MB section or a pointer to a second-level table. For a pointer, the block reads the second-level entry selected by address bits 19:12. That entry is either invalid, a 64 KB large page or a 4 KB small page.

The walk ends with a one-cycle result. The result carries the physical address, a size code, the domain, a 3-bit permission field, the execute-never, not-global and shareable flags, the TEX/C/B memory attributes, the non-secure flag and a fault code. When access-flag management is on and the final descriptor has its access bit clear, the block sets that bit. It then writes the descriptor back to the address it was read from before it reports the result. Descriptor reads and the write-back share one request port. Reads return data on a separate response strobe, and a write completes when it is accepted.

Top module: `sdw_walker`

## Requirements
- R1: During and right after a synchronous active-low reset, `walk_ready` is 1, and `mem_req_valid` and `res_valid` are 0. A reset in the middle of a walk abandons that walk.
- R2: The first-level read address is `{ttb_base, va[31:20], 2'b00}`. The second-level read address is `{L1[31:10], va[19:12], 2'b00}`.
- R3: A first-level type field `L1[1:0]` of 0 or 3 ends the walk with fault code 1. On any fault, every result field other than `res_fault` is 0, and no second-level read or write-back occurs.
- R4: A section (`L1[1:0]=2`, bit 18 clear) gives `res_size=0` and `res_pa={L1[31:20], va[19:0]}`. It also gives domain `L1[8:5]`, permission `{L1[15], L1[11:10]}`, execute-never `L1[4]`, not-global `L1[17]`, shareable `L1[16]`, TEX `L1[14:12]`, C `L1[3]` and B `L1[2]`.
- R5: A section with bit 18 set ends the walk with fault code 2.
- R6: A second-level entry with `L2[1:0]=0` ends the walk with fault code 3.
- R7: A large page (`L2[1]=0`, `L2[0]=1`) gives `res_size=1`, `res_pa={L2[31:16], va[15:0]}`, execute-never `L2[15]` and TEX `L2[14:12]`.
- R8: A small page (`L2[1]=1`) gives `res_size=2`, `res_pa={L2[31:12], va[11:0]}`, execute-never `L2[0]` and TEX `L2[8:6]`.
- R9: For both page sizes, the permission is `{L2[9], L2[5:4]}`, not-global is `L2[11]`, shareable is `L2[10]`, C is `L2[3]` and B is `L2[2]`. The domain comes from the parent first-level entry `L1[8:5]`.
- R10: `res_ns` is 0 when `sec_en` is 0. Otherwise it is `L1[19]` for a section and the parent's `L1[3]` for a page.
- R11: When `af_en` is 1 and the final descriptor's access bit is clear, exactly one write is issued before the result, to the address the descriptor was read from. The access bit is bit 10 for a section and bit 4 for a page. The write data is that descriptor with the access bit set, and the reported permission bit 0 is then 1. When `af_en` is 0 or the bit is already set, no write occurs.
- R12: Only one walk runs at a time. `walk_ready` is 0 from acceptance until the result. `walk_valid` and the other start inputs are ignored while busy, and `res_valid` lasts exactly one cycle.
- R13: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request's address, direction and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| walk_valid | input | 1 | Start a walk (taken when `walk_ready`) |
| walk_ready | output | 1 | Block idle, able to take a walk |
| walk_va | input | 32 | Virtual address to translate |
| ttb_base | input | 18 | First-level table base, address bits 31:14 |
| af_en | input | 1 | Hardware access-bit update enabled |
| sec_en | input | 1 | Security support enabled |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = descriptor write-back, 0 = read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read descriptor |
| res_valid | output | 1 | Result valid, one cycle |
| res_fault | output | 2 | 0 none, 1 first-level, 2 supersection, 3 second-level |
| res_size | output | 2 | 0 section, 1 large page, 2 small page |
| res_pa | output | 32 | Physical address |
| res_domain | output | 4 | Domain number |
| res_ap | output | 3 | Permission bits |
| res_xn | output | 1 | Execute-never |
| res_ng | output | 1 | Not-global |
| res_shared | output | 1 | Shareable |
| res_tex | output | 3 | TEX attribute |
| res_c | output | 1 | C attribute |
| res_b | output | 1 | B attribute |
| res_ns | output | 1 | Non-secure |

## Verification
A table of walks covers each first-level type code, the supersection bit, and each second-level form including the invalid code. The entries are chosen so that every result field differs between section, large-page and small-page decoding, and a field read from the wrong bit position shows up as a wrong value. Access bits are set or cleared with `af_en` on or off, which separates walks that must write back from walks that must not. Memory is read back afterwards to confirm the written word. Directed walks then check the exact request addresses, the attribute positions for each format, `sec_en` masking, walks under request back-pressure with a competing `walk_valid` held high, and a reset issued mid-walk.

// File: rtl/sdw_pkg.sv
// Shared constants and types for the short-format table walker.
// Assumes 32-bit virtual/physical addresses and 32-bit descriptors.
package sdw_pkg;
    localparam int VA_W       = 32;
    localparam int DESC_W     = 32;
    localparam int L1_IDX_W   = 12;
    localparam int L2_IDX_W   = 8;
    localparam int ENT_SHIFT  = 2;                               // 4-byte entries
    localparam int TTB_W      = VA_W - L1_IDX_W - ENT_SHIFT;     // 18
    localparam int L2_BASE_W  = DESC_W - L2_IDX_W - ENT_SHIFT;   // 22
    localparam int SECT_OFF_W = VA_W - L1_IDX_W;                 // 20
    localparam int LRG_OFF_W  = 16;
    localparam int SML_OFF_W  = SECT_OFF_W - L2_IDX_W;           // 12
    localparam int DOM_W      = 4;
    localparam int L1_ACC_BIT = 10;
    localparam int L2_ACC_BIT = 4;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_L1    = 2'd1,
        FLT_SUPER = 2'd2,
        FLT_L2    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        SZ_SECTION = 2'd0,
        SZ_LARGE   = 2'd1,
        SZ_SMALL   = 2'd2,
        SZ_NONE    = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        L1K_FAULT = 2'd0,
        L1K_TABLE = 2'd1,
        L1K_SECT  = 2'd2,
        L1K_RSVD  = 2'd3
    } l1_kind_e;

    typedef struct packed {
        logic [VA_W-1:0]  pa;
        logic [1:0]       size;
        logic [DOM_W-1:0] dom;
        logic [2:0]       ap;
        logic             xn;
        logic             ng;
        logic             shr;
        logic [2:0]       tex;
        logic             c;
        logic             b;
        logic             ns;
    } map_t;
endpackage

// File: rtl/sdw_l1_dec.sv
// First-level descriptor decoder (combinational).
// Classifies the entry and extracts section mapping fields, the
// second-level table base and the attributes a pointer passes down.
// Assumes the descriptor is held stable by the controller.
module sdw_l1_dec
    import sdw_pkg::*;
(
    input  logic [DESC_W-1:0]    desc,
    input  logic [VA_W-1:0]      va,
    input  logic                 sec_en,
    output l1_kind_e             kind,
    output logic                 is_super,
    output logic [L2_BASE_W-1:0] l2_base,
    output logic [DOM_W-1:0]     ptr_dom,
    output logic                 ptr_ns,
    output map_t                 sect_map
);
    // Type code, supersection flag and pointer fields
    always_comb begin
        kind     = l1_kind_e'(desc[1:0]);
        is_super = desc[18];
        l2_base  = desc[DESC_W-1 -: L2_BASE_W];
        ptr_dom  = desc[8:5];
        ptr_ns   = sec_en & desc[3];
    end

    // Section mapping fields
    always_comb begin
        sect_map      = '0;
        sect_map.pa   = {desc[DESC_W-1 -: L1_IDX_W], va[SECT_OFF_W-1:0]};
        sect_map.size = SZ_SECTION;
        sect_map.dom  = desc[8:5];
        sect_map.ap   = {desc[15], desc[11:10]};
        sect_map.xn   = desc[4];
        sect_map.ng   = desc[17];
        sect_map.shr  = desc[16];
        sect_map.tex  = desc[14:12];
        sect_map.c    = desc[3];
        sect_map.b    = desc[2];
        sect_map.ns   = sec_en & desc[19];
    end
endmodule

// File: rtl/sdw_l2_dec.sv
// Second-level descriptor decoder (combinational).
// Selects large/small page format and merges the parent's domain and
// security state. Assumes an invalid entry is screened by the caller.
module sdw_l2_dec
    import sdw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [VA_W-1:0]   va,
    input  logic [DOM_W-1:0]  parent_dom,
    input  logic              parent_ns,
    output logic              invalid,
    output map_t              page_map
);
    logic is_large;

    // Format selection from the low two bits
    always_comb begin
        invalid  = (desc[1:0] == 2'b00);
        is_large = ~desc[1];
    end

    // Page mapping fields, size-dependent positions first
    always_comb begin
        page_map = '0;
        if (is_large) begin
            page_map.pa   = {desc[DESC_W-1 -: (VA_W-LRG_OFF_W)], va[LRG_OFF_W-1:0]};
            page_map.size = SZ_LARGE;
            page_map.xn   = desc[15];
            page_map.tex  = desc[14:12];
        end else begin
            page_map.pa   = {desc[DESC_W-1 -: (VA_W-SML_OFF_W)], va[SML_OFF_W-1:0]};
            page_map.size = SZ_SMALL;
            page_map.xn   = desc[0];
            page_map.tex  = desc[8:6];
        end
        page_map.ap  = {desc[9], desc[5:4]};
        page_map.ng  = desc[11];
        page_map.shr = desc[10];
        page_map.c   = desc[3];
        page_map.b   = desc[2];
        page_map.dom = parent_dom;
        page_map.ns  = parent_ns;
    end
endmodule

// File: rtl/sdw_walk_ctl.sv
// Walk sequencer: owns the request port, the captured walk context and
// the descriptor registers. Each response is registered and evaluated
// one cycle later. Access-bit updates are made in the held descriptor
// and written back to the last read address. Assumes a write completes
// on acceptance and a read returns exactly one response.
module sdw_walk_ctl
    import sdw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 walk_valid,
    input  logic [VA_W-1:0]      walk_va,
    input  logic [TTB_W-1:0]     ttb_base,
    input  logic                 af_en,
    input  logic                 sec_en,
    output logic                 walk_ready,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_write,
    output logic [VA_W-1:0]      mem_req_addr,
    output logic [DESC_W-1:0]    mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [DESC_W-1:0]    mem_rsp_data,
    input  l1_kind_e             l1_kind,
    input  logic                 l1_super,
    input  logic [L2_BASE_W-1:0] l1_l2base,
    input  logic                 l2_invalid,
    output logic [VA_W-1:0]      va_q,
    output logic [DESC_W-1:0]    l1_q,
    output logic [DESC_W-1:0]    l2_q,
    output logic                 sec_q,
    output logic                 use_l2_q,
    output fault_e               fault_q,
    output logic                 done
);
    typedef enum logic [3:0] {
        S_IDLE, S_L1_RD, S_L1_WT, S_L1_EV,
        S_L2_RD, S_L2_WT, S_L2_EV, S_WB, S_DONE
    } st_e;

    st_e              state_q;
    logic             af_q;
    logic [VA_W-1:0]  addr_q;

    // Walk sequencing, context capture and descriptor update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            va_q     <= '0;
            l1_q     <= '0;
            l2_q     <= '0;
            af_q     <= 1'b0;
            sec_q    <= 1'b0;
            use_l2_q <= 1'b0;
            fault_q  <= FLT_NONE;
            addr_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (walk_valid) begin
                    va_q     <= walk_va;
                    af_q     <= af_en;
                    sec_q    <= sec_en;
                    use_l2_q <= 1'b0;
                    fault_q  <= FLT_NONE;
                    l1_q     <= '0;
                    l2_q     <= '0;
                    addr_q   <= {ttb_base, walk_va[VA_W-1 -: L1_IDX_W], {ENT_SHIFT{1'b0}}};
                    state_q  <= S_L1_RD;
                end
                S_L1_RD: if (mem_req_ready) state_q <= S_L1_WT;
                S_L1_WT: if (mem_rsp_valid) begin
                    l1_q    <= mem_rsp_data;
                    state_q <= S_L1_EV;
                end
                S_L1_EV: begin
                    if (l1_kind == L1K_SECT) begin
                        if (l1_super) begin
                            fault_q <= FLT_SUPER;
                            state_q <= S_DONE;
                        end else if (af_q && !l1_q[L1_ACC_BIT]) begin
                            l1_q[L1_ACC_BIT] <= 1'b1;
                            state_q          <= S_WB;
                        end else begin
                            state_q <= S_DONE;
                        end
                    end else if (l1_kind == L1K_TABLE) begin
                        addr_q   <= {l1_l2base, va_q[SECT_OFF_W-1 -: L2_IDX_W], {ENT_SHIFT{1'b0}}};
                        use_l2_q <= 1'b1;
                        state_q  <= S_L2_RD;
                    end else begin
                        fault_q <= FLT_L1;
                        state_q <= S_DONE;
                    end
                end
                S_L2_RD: if (mem_req_ready) state_q <= S_L2_WT;
                S_L2_WT: if (mem_rsp_valid) begin
                    l2_q    <= mem_rsp_data;
                    state_q <= S_L2_EV;
                end
                S_L2_EV: begin
                    if (l2_invalid) begin
                        fault_q <= FLT_L2;
                        state_q <= S_DONE;
                    end else if (af_q && !l2_q[L2_ACC_BIT]) begin
                        l2_q[L2_ACC_BIT] <= 1'b1;
                        state_q          <= S_WB;
                    end else begin
                        state_q <= S_DONE;
                    end
                end
                S_WB:    if (mem_req_ready) state_q <= S_DONE;
                S_DONE:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Request port and handshake outputs
    always_comb begin
        walk_ready    = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_L1_RD) || (state_q == S_L2_RD) || (state_q == S_WB);
        mem_req_write = (state_q == S_WB);
        mem_req_addr  = addr_q;
        mem_req_wdata = (state_q == S_WB) ? (use_l2_q ? l2_q : l1_q) : '0;
        done          = (state_q == S_DONE);
    end
endmodule

// File: rtl/sdw_walker.sv
// Top of the short-format two-level table walker. Connects the
// sequencer to both decoders and presents the result, zeroed when
// idle or faulted. Assumes one outstanding memory read at a time.
module sdw_walker
    import sdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              walk_valid,
    output logic              walk_ready,
    input  logic [31:0]       walk_va,
    input  logic [17:0]       ttb_base,
    input  logic              af_en,
    input  logic              sec_en,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [31:0]       mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              res_valid,
    output logic [1:0]        res_fault,
    output logic [1:0]        res_size,
    output logic [31:0]       res_pa,
    output logic [3:0]        res_domain,
    output logic [2:0]        res_ap,
    output logic              res_xn,
    output logic              res_ng,
    output logic              res_shared,
    output logic [2:0]        res_tex,
    output logic              res_c,
    output logic              res_b,
    output logic              res_ns
);
    l1_kind_e             l1_kind;
    logic                 l1_super;
    logic [L2_BASE_W-1:0] l1_l2base;
    logic [DOM_W-1:0]     ptr_dom;
    logic                 ptr_ns;
    logic                 l2_invalid;
    logic [VA_W-1:0]      va_q;
    logic [DESC_W-1:0]    l1_q;
    logic [DESC_W-1:0]    l2_q;
    logic                 sec_q;
    logic                 use_l2_q;
    fault_e               fault_q;
    logic                 done;
    map_t                 sect_map;
    map_t                 page_map;
    map_t                 out_map;

    sdw_walk_ctl u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .walk_valid    (walk_valid),
        .walk_va       (walk_va),
        .ttb_base      (ttb_base),
        .af_en         (af_en),
        .sec_en        (sec_en),
        .walk_ready    (walk_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .l1_kind       (l1_kind),
        .l1_super      (l1_super),
        .l1_l2base     (l1_l2base),
        .l2_invalid    (l2_invalid),
        .va_q          (va_q),
        .l1_q          (l1_q),
        .l2_q          (l2_q),
        .sec_q         (sec_q),
        .use_l2_q      (use_l2_q),
        .fault_q       (fault_q),
        .done          (done)
    );

    sdw_l1_dec u_l1 (
        .desc     (l1_q),
        .va       (va_q),
        .sec_en   (sec_q),
        .kind     (l1_kind),
        .is_super (l1_super),
        .l2_base  (l1_l2base),
        .ptr_dom  (ptr_dom),
        .ptr_ns   (ptr_ns),
        .sect_map (sect_map)
    );

    sdw_l2_dec u_l2 (
        .desc       (l2_q),
        .va         (va_q),
        .parent_dom (ptr_dom),
        .parent_ns  (ptr_ns),
        .invalid    (l2_invalid),
        .page_map   (page_map)
    );

    // Pick the level that ended the walk; blank on fault or when idle
    always_comb begin
        if (done && fault_q == FLT_NONE)
            out_map = use_l2_q ? page_map : sect_map;
        else
            out_map = '0;
    end

    // Drive result ports from the selected mapping
    always_comb begin
        res_valid  = done;
        res_fault  = done ? fault_q : FLT_NONE;
        res_size   = out_map.size;
        res_pa     = out_map.pa;
        res_domain = out_map.dom;
        res_ap     = out_map.ap;
        res_xn     = out_map.xn;
        res_ng     = out_map.ng;
        res_shared = out_map.shr;
        res_tex    = out_map.tex;
        res_c      = out_map.c;
        res_b      = out_map.b;
        res_ns     = out_map.ns;
    end
endmodule

// File: rtl/sdw_walker_chk.sv
// Property checker for sdw_walker, attached by bind. Tracks the
// accepted address, the access-update mode and the last read address
// on its own, from the ports.
module sdw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        walk_valid,
    input logic        walk_ready,
    input logic [31:0] walk_va,
    input logic        af_en,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [31:0] mem_req_addr,
    input logic [31:0] mem_req_wdata,
    input logic        res_valid,
    input logic [1:0]  res_fault,
    input logic [1:0]  res_size,
    input logic [31:0] res_pa,
    input logic [2:0]  res_ap
);
    logic [31:0] va_cap;
    logic        af_cap;
    logic [31:0] last_rd;

    // Shadow of the walk context taken at the port handshakes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_cap  <= '0;
            af_cap  <= 1'b0;
            last_rd <= '0;
        end else begin
            if (walk_valid && walk_ready) begin
                va_cap <= walk_va;
                af_cap <= af_en;
            end
            if (mem_req_valid && mem_req_ready && !mem_req_write)
                last_rd <= mem_req_addr;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (walk_ready && !mem_req_valid && !res_valid));

    p_fault_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != 2'd0) |-> (res_pa == 32'd0 && res_ap == 3'd0 && res_size == 2'd0));

    p_sect_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd0 && res_size == 2'd0) |-> (res_pa[19:0] == va_cap[19:0]));

    p_large_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd0 && res_size == 2'd1) |-> (res_pa[15:0] == va_cap[15:0]));

    p_small_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd0 && res_size == 2'd2) |-> (res_pa[11:0] == va_cap[11:0]));

    p_wb_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_addr == last_rd));

    p_ap0_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd0 && af_cap) |-> res_ap[0]);

    p_res_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !walk_ready);

    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
endmodule

bind sdw_walker sdw_walker_chk u_sdw_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_valid    (walk_valid),
    .walk_ready    (walk_ready),
    .walk_va       (walk_va),
    .af_en         (af_en),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .res_valid     (res_valid),
    .res_fault     (res_fault),
    .res_size      (res_size),
    .res_pa        (res_pa),
    .res_ap        (res_ap)
);

// File: tb/sdw_walker_bench.sv
module sdw_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_valid = 1'b0;
    logic        walk_ready;
    logic [31:0] walk_va = '0;
    logic [17:0] ttb_base = 18'h1;
    logic        af_en = 1'b0;
    logic        sec_en = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [1:0]  res_fault;
    logic [1:0]  res_size;
    logic [31:0] res_pa;
    logic [3:0]  res_domain;
    logic [2:0]  res_ap;
    logic        res_xn, res_ng, res_shared, res_c, res_b, res_ns;
    logic [2:0]  res_tex;

    always #2.5 clk = ~clk;   // 200 MHz

    sdw_walker u_sdw_walker (.*);

    // Bench memory: 4096 words, indexed by address bits 13:2
    logic [31:0] mem [0:4095];
    logic        ld_en = 1'b0;
    logic [11:0] ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic        stall_mode = 1'b0;
    int          log_n = 0;
    logic [31:0] log_addr [0:15];
    logic        log_wr   [0:15];
    logic [31:0] log_data [0:15];

    // Responder: one-cycle read latency, writes land on acceptance
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (ld_en) mem[ld_idx] <= ld_data;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) mem[mem_req_addr[13:2]] <= mem_req_wdata;
            else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[mem_req_addr[13:2]];
            end
            log_addr[log_n[3:0]] <= mem_req_addr;
            log_wr[log_n[3:0]]   <= mem_req_write;
            log_data[log_n[3:0]] <= mem_req_wdata;
            log_n <= log_n + 1;
        end
    end

    // Request back-pressure pattern
    always @(negedge clk) mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;

    typedef struct packed {
        logic [31:0] va; logic [31:0] l1; logic [31:0] l2;
        logic af; logic sec;
        logic [31:0] pa; logic [1:0] size; logic [1:0] fault;
        logic [3:0] dom; logic [2:0] ap; logic xn; logic ns; logic wb;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{32'h1234_5678, 32'hABC0_04B2, 32'h0, 1'b1, 1'b0, 32'hABC4_5678, 2'd0, 2'd0, 4'h5, 3'd1, 1'b1, 1'b0, 1'b0},
        '{32'h0010_0010, 32'h8008_89E2, 32'h0, 1'b1, 1'b1, 32'h8000_0010, 2'd0, 2'd0, 4'hF, 3'd7, 1'b0, 1'b1, 1'b1},
        '{32'h4560_0000, 32'hFFFF_FFFC, 32'h0, 1'b1, 1'b1, 32'h0,         2'd0, 2'd1, 4'h0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{32'h4570_0000, 32'h0000_0003, 32'h0, 1'b1, 1'b1, 32'h0,         2'd0, 2'd1, 4'h0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{32'h7FF0_0000, 32'h0004_0002, 32'h0, 1'b1, 1'b1, 32'h0,         2'd0, 2'd2, 4'h0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{32'h0021_2345, 32'h0000_2C69, 32'h1234_5233, 1'b1, 1'b1, 32'h1234_5345, 2'd2, 2'd0, 4'h3, 3'd7, 1'b1, 1'b1, 1'b0},
        '{32'h003A_BCDE, 32'h0000_2D21, 32'h7777_8021, 1'b1, 1'b1, 32'h7777_BCDE, 2'd1, 2'd0, 4'h9, 3'd3, 1'b1, 1'b0, 1'b1},
        '{32'h0040_5000, 32'h0000_2C01, 32'h0, 1'b1, 1'b1, 32'h0,         2'd0, 2'd3, 4'h0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{32'h0050_0000, 32'h5550_0002, 32'h0, 1'b0, 1'b0, 32'h5550_0000, 2'd0, 2'd0, 4'h0, 3'd0, 1'b0, 1'b0, 1'b0}
    };

    int n_tests = 0;
    int n_fail  = 0;
    int base_n;
    logic seen_busy;
    logic timed_out;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] l1_idx(input logic [31:0] va);
        return va[31:20];
    endfunction

    function automatic logic [11:0] l2_idx(input logic [31:0] l1, input logic [31:0] va);
        logic [31:0] a;
        a = {l1[31:10], va[19:12], 2'b00};
        return a[13:2];
    endfunction

    task automatic poke(input logic [11:0] idx, input logic [31:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_walk(input logic [31:0] va, input logic af, input logic sec, input bit hold);
        int n;
        base_n = log_n;
        seen_busy = 1'b0;
        timed_out = 1'b0;
        @(negedge clk);
        walk_va = va; af_en = af; sec_en = sec; walk_valid = 1'b1;
        @(negedge clk);
        if (hold) begin
            walk_va = 32'h1234_5678; af_en = 1'b0; sec_en = 1'b0;
        end else walk_valid = 1'b0;
        n = 0;
        while (!res_valid && n < 200) begin
            if (!walk_ready) seen_busy = 1'b1;
            @(negedge clk);
            n++;
        end
        walk_valid = 1'b0;
        if (n >= 200) timed_out = 1'b1;
    endtask

    function automatic int writes_since(input int b);
        int w = 0;
        for (int i = b; i < log_n; i++) if (log_wr[i % 16]) w++;
        return w;
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'd0, walk_ready}, 32'd1);
        chk("R1 no request in reset", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 no result in reset", {31'd0, res_valid}, 32'd0);
        rst_n = 1'b1;

        // Table of walks
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            logic [11:0] fidx;
            logic [31:0] fexp;
            t = VT[v];
            poke(l1_idx(t.va), t.l1);
            if (t.l1[1:0] == 2'b01) poke(l2_idx(t.l1, t.va), t.l2);
            run_walk(t.va, t.af, t.sec, 1'b0);
            chk("R12 walk finished", {31'd0, timed_out}, 32'd0);
            chk("R3 R5 R6 fault code", {30'd0, res_fault}, {30'd0, t.fault});
            chk("R4 R7 R8 physical address", res_pa, t.pa);
            chk("R4 R7 R8 size code", {30'd0, res_size}, {30'd0, t.size});
            chk("R9 domain", {28'd0, res_domain}, {28'd0, t.dom});
            chk("R11 permission", {29'd0, res_ap}, {29'd0, t.ap});
            chk("R4 R7 R8 execute-never", {31'd0, res_xn}, {31'd0, t.xn});
            chk("R10 non-secure", {31'd0, res_ns}, {31'd0, t.ns});
            @(negedge clk);
            chk("R12 result one cycle", {31'd0, res_valid}, 32'd0);
            chk("R11 write count", writes_since(base_n), {31'd0, t.wb});
            if (t.l1[1:0] == 2'b01) begin
                fidx = l2_idx(t.l1, t.va);
                fexp = t.wb ? (t.l2 | 32'h10) : t.l2;
            end else begin
                fidx = l1_idx(t.va);
                fexp = t.wb ? (t.l1 | 32'h400) : t.l1;
            end
            chk("R11 memory after walk", mem[fidx], fexp);
        end

        // R2: request addresses for a two-level walk
        run_walk(32'h0021_2345, 1'b1, 1'b1, 1'b0);
        chk("R2 request count", log_n - base_n, 2);
        chk("R2 first-level address", log_addr[base_n % 16], 32'h0000_4008);
        chk("R2 second-level address", log_addr[(base_n + 1) % 16], 32'h0000_2C48);

        // R11: write-back address and data for a large page
        poke(12'hBAB, 32'h7777_8021);
        run_walk(32'h003A_BCDE, 1'b1, 1'b0, 1'b0);
        chk("R11 write-back is third request", log_n - base_n, 3);
        chk("R11 write-back flag", {31'd0, log_wr[(base_n + 2) % 16]}, 32'd1);
        chk("R11 write-back address", log_addr[(base_n + 2) % 16], 32'h0000_2EAC);
        chk("R11 write-back data", log_data[(base_n + 2) % 16], 32'h7777_8031);
        chk("R10 page ns masked", {31'd0, res_ns}, 32'd0);

        // R4: section attribute positions
        poke(12'h006, 32'h0F03_540E);
        run_walk(32'h0060_0000, 1'b0, 1'b0, 1'b0);
        chk("R4 section pa", res_pa, 32'h0F00_0000);
        chk("R4 section tex", {29'd0, res_tex}, 32'd5);
        chk("R4 section c", {31'd0, res_c}, 32'd1);
        chk("R4 section b", {31'd0, res_b}, 32'd1);
        chk("R4 section shareable", {31'd0, res_shared}, 32'd1);
        chk("R4 section not-global", {31'd0, res_ng}, 32'd1);
        chk("R4 section ap", {29'd0, res_ap}, 32'd1);

        // R10 and R11: security off masks ns; update off leaves access bit clear
        poke(12'h001, 32'h8008_89E2);
        run_walk(32'h0010_0010, 1'b0, 1'b0, 1'b0);
        chk("R10 section ns masked", {31'd0, res_ns}, 32'd0);
        chk("R11 no update ap", {29'd0, res_ap}, 32'd6);
        chk("R11 no write when disabled", writes_since(base_n), 0);

        // R7 and R9: large-page attributes
        poke(12'h007, 32'h0000_2C01);
        poke(12'hB01, 32'h1111_6C11);
        run_walk(32'h0070_1000, 1'b1, 1'b1, 1'b0);
        chk("R7 large pa", res_pa, 32'h1111_1000);
        chk("R7 large tex", {29'd0, res_tex}, 32'd6);
        chk("R7 large xn", {31'd0, res_xn}, 32'd0);
        chk("R9 large not-global", {31'd0, res_ng}, 32'd1);
        chk("R9 large shareable", {31'd0, res_shared}, 32'd1);
        chk("R9 large c b", {30'd0, res_c, res_b}, 32'd0);

        // R8 and R9: small-page attributes
        poke(12'h008, 32'h0000_2C01);
        poke(12'hB02, 32'h2222_20D6);
        run_walk(32'h0080_2ABC, 1'b1, 1'b1, 1'b0);
        chk("R8 small pa", res_pa, 32'h2222_2ABC);
        chk("R8 small size", {30'd0, res_size}, 32'd2);
        chk("R8 small tex", {29'd0, res_tex}, 32'd3);
        chk("R8 small xn", {31'd0, res_xn}, 32'd0);
        chk("R9 small c b", {30'd0, res_c, res_b}, 32'd1);
        chk("R9 small ap", {29'd0, res_ap}, 32'd1);

        // R12 and R13: back-pressure with a competing start held high
        stall_mode = 1'b1;
        run_walk(32'h0021_2345, 1'b1, 1'b1, 1'b1);
        chk("R13 walk under stall finished", {31'd0, timed_out}, 32'd0);
        chk("R12 busy observed", {31'd0, seen_busy}, 32'd1);
        chk("R12 second start ignored pa", res_pa, 32'h1234_5345);
        chk("R12 second start ignored ns", {31'd0, res_ns}, 32'd1);
        chk("R13 request count under stall", log_n - base_n, 2);
        stall_mode = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset in the middle of a walk
        @(negedge clk);
        walk_va = 32'h0021_2345; walk_valid = 1'b1;
        @(negedge clk);
        walk_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-walk reset ready", {31'd0, walk_ready}, 32'd1);
        chk("R1 mid-walk reset request", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 mid-walk reset result", {31'd0, res_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end
endmodule